// File: doc/BRIEF.md
# Thermometer-Code Edge Transition Encoder

This block sits behind a delay-line sampler in one channel of a multi-hit time digitizer. On every system clock cycle it may accept a snapshot of 32 sample bits, each bit covering one thirty-second of the clock period. Bit 0 is the earliest sample and bit 31 the latest. From each snapshot it produces two 6-bit codes. The rising code gives the position of a low-to-high change. The falling code gives the position of a high-to-low change. Each code carries a hit tag in its top bit.

The last sample of each accepted snapshot is kept in a register. An edge that falls between the end of one word and the start of the next is therefore still seen. It is reported in the cycle that carries the new first bit. When a code has no edge to report, its position field does not stay unused: it tells the reader the level at which the word starts. The downstream memory can then tell a steady low input from a steady high one. Both codes are registered and appear one cycle after the snapshot, together with a valid strobe.

Top module: `thermo_edge_enc`

## Requirements
- R1: A snapshot accepted with `in_valid` high produces `out_valid` high on the next cycle; a cycle with `in_valid` low produces `out_valid` low on the next cycle.
- R2: A rising change between bit k (0) and bit k+1 (1), for k from 0 to 30, gives `rise_code` = {1'b1, k[4:0]}; bit 5 is the hit tag, bits 4..0 the position.
- R3: A falling change between bit k (1) and bit k+1 (0), for k from 0 to 30, gives `fall_code` = {1'b1, k[4:0]} in the same layout.
- R4: If the held last bit of the previous accepted snapshot is 0 and bit 0 of the new snapshot is 1, `rise_code` for the new snapshot is {1'b1, 5'd31}.
- R5: If the held bit is 1 and bit 0 of the new snapshot is 0, `fall_code` for the new snapshot is {1'b1, 5'd31}.
- R6: When several edges of one polarity are present, the one at the highest position is reported; the boundary edge (position 31) outranks every interior edge.
- R7: With no rising edge, `rise_code` is {1'b0, 4'b0, s0}, where s0 is bit 0 of the snapshot: 0 for an all-zero word, 1 for an all-one word or a word that starts high.
- R8: With no falling edge, `fall_code` is {1'b0, 4'b0, ~s0}: 0 for an all-one word, 1 for an all-zero word or a word that starts low.
- R9: Reset clears the held bit to 0 and drives `out_valid`, `rise_code` and `fall_code` to 0; an all-one first snapshot after reset therefore reports a rising edge at position 31.
- R10: Cycles with `in_valid` low leave the held bit unchanged, whatever `sample` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Snapshot on `sample` is accepted this cycle |
| sample | input | 32 | Sample bits, bit 0 earliest |
| out_valid | output | 1 | Codes are valid this cycle |
| rise_code | output | 6 | Hit tag (bit 5) and position or level (bits 4..0) for rising edges |
| fall_code | output | 6 | Hit tag (bit 5) and position or level (bits 4..0) for falling edges |

## Verification
The boundary edge and interior edges can land in the same snapshot. In that case the priority rule decides which one is reported. To provoke this, a word with a pattern repeating every eight bits is sent after a word that ends low, which gives a wrap edge together with several interior rising edges. A word beginning 0 is also sent after one ending 1, which gives a wrap falling edge and an interior rising edge at position 0 in the same cycle. The results are judged by checking that position 31 wins the rising code in the first case, and that both codes carry their own hits in the second.

// File: rtl/thermo_edge_enc.sv
module thermo_edge_enc #(
  parameter int N = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [N-1:0]     sample,
  output logic             out_valid,
  output logic [$clog2(N):0] rise_code,
  output logic [$clog2(N):0] fall_code
);
  localparam int POS_W = $clog2(N);
  localparam logic [POS_W-1:0] WRAP_POS = POS_W'(N - 1);

  logic             held_q;
  logic             r_hit, f_hit;
  logic [POS_W-1:0] r_pos, f_pos;

  always_comb begin
    r_hit = 1'b0;
    f_hit = 1'b0;
    r_pos = '0;
    f_pos = '0;
    for (int k = 0; k < N - 1; k++) begin
      if (!sample[k] && sample[k+1]) begin
        r_hit = 1'b1;
        r_pos = POS_W'(k);
      end
      if (sample[k] && !sample[k+1]) begin
        f_hit = 1'b1;
        f_pos = POS_W'(k);
      end
    end
    if (!held_q && sample[0]) begin
      r_hit = 1'b1;
      r_pos = WRAP_POS;
    end
    if (held_q && !sample[0]) begin
      f_hit = 1'b1;
      f_pos = WRAP_POS;
    end
    if (!r_hit) r_pos = POS_W'(sample[0]);
    if (!f_hit) f_pos = POS_W'(!sample[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q    <= 1'b0;
      out_valid <= 1'b0;
      rise_code <= '0;
      fall_code <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        held_q    <= sample[N-1];
        rise_code <= {r_hit, r_pos};
        fall_code <= {f_hit, f_pos};
      end
    end
  end
endmodule

// File: rtl/thermo_edge_enc_chk.sv
module thermo_edge_enc_chk #(
  parameter int N = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [N-1:0]       sample,
  input logic               held_q,
  input logic               out_valid,
  input logic [$clog2(N):0] rise_code,
  input logic [$clog2(N):0] fall_code
);
  localparam int POS_W = $clog2(N);
  localparam logic [POS_W:0] WRAP_CODE = {1'b1, POS_W'(N - 1)};

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r4_wrap_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !held_q && sample[0]) |=> rise_code == WRAP_CODE);
  a_r5_wrap_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && held_q && !sample[0]) |=> fall_code == WRAP_CODE);
  a_r7_all_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sample == '0) |=> rise_code == '0);
  a_r8_all_one: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && &sample && held_q) |=> (fall_code == '0 && rise_code == (POS_W+1)'(1)));
  a_r7_nohit_field: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !rise_code[POS_W]) |-> rise_code[POS_W-1:0] <= 1);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(held_q));
endmodule

bind thermo_edge_enc thermo_edge_enc_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sample(sample),
  .held_q(held_q), .out_valid(out_valid),
  .rise_code(rise_code), .fall_code(fall_code)
);

// File: tb/sim_thermo_edge_enc.sv
module sim_thermo_edge_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] sample = '0;
  logic        out_valid;
  logic [5:0]  rise_code, fall_code;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  thermo_edge_enc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sample(sample),
    .out_valid(out_valid), .rise_code(rise_code), .fall_code(fall_code)
  );

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] w, input logic [5:0] er, input logic [5:0] ef,
                      input string req);
    in_valid = 1'b1;
    sample   = w;
    @(negedge clk);
    check({req, " R1 valid"}, {5'b0, out_valid}, 6'd1);
    check({req, " rise"}, rise_code, er);
    check({req, " fall"}, fall_code, ef);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      sample = 32'h0000_0000;
      @(negedge clk);
      check("R1 idle no valid", {5'b0, out_valid}, 6'd0);
    end
  endtask

  task automatic t_reset;
    check("R9 reset valid", {5'b0, out_valid}, 6'd0);
    check("R9 reset rise", rise_code, 6'h00);
    check("R9 reset fall", fall_code, 6'h00);
    step(32'hFFFF_FFFF, 6'h3F, 6'h00, "R9 R4 R8 first ones");
    idle(1);
  endtask

  task automatic t_interior;
    step(32'h0000_00FF, 6'h01, 6'h27, "R3 R7 fall pos7");
    step(32'h0000_0F00, 6'h27, 6'h2B, "R2 rise7 fall11");
    idle(1);
  endtask

  task automatic t_priority;
    step(32'h0F0F_0F0F, 6'h3F, 6'h3B, "R6 R4 wrap wins");
    step(32'h0000_0000, 6'h00, 6'h01, "R7 R8 all zero");
    idle(1);
  endtask

  task automatic t_wrap_fall;
    step(32'h8000_0000, 6'h3E, 6'h01, "R2 rise pos30");
    step(32'hFFFF_FFFE, 6'h20, 6'h3F, "R5 R2 wrap fall and rise0");
  endtask

  task automatic t_hold;
    idle(4);
    step(32'hFFFF_FFFF, 6'h01, 6'h00, "R10 held bit kept");
    step(32'h7FFF_FFFF, 6'h01, 6'h3E, "R3 fall pos30");
    step(32'h0000_0001, 6'h3F, 6'h20, "R4 R3 wrap rise fall0");
    idle(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_interior();
    t_priority();
    t_wrap_fall();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule